// File: doc/BRIEF.md
# Event Status and Interrupt Register Block

This block sits behind the host register port of an instrument-bus interface card. Hardware events come in as single-cycle pulses or levels from the bus controller chip and the transfer engine. They are latched into an event status byte. The host reads the byte and clears bits by writing 1 to them.

Two separate masks shape the behaviour:
- An event-enable mask decides whether an event is recorded at all.
- An interrupt-enable mask decides which recorded events count towards the host interrupt.

A read-only pending bit, placed inside the status byte, reports whether any recorded event is also interrupt-enabled. The interrupt line reaches the host only when the interrupt-gate bit of the mode register is set.

The host side is a byte-wide port with a 3-bit offset, a write strobe and a read strobe. Reads are registered: the byte at the offset sampled on a read-strobe cycle appears on the read-data output after that clock edge, and it is held until the next read. Reset is synchronous and active high.

Top module: `evtirq_block`

## Requirements
- R1: A synchronous reset clears every register, the read-data output and the interrupt output to 0.
- R2: A status bit at an event position (0x01 controller-chip interrupt, 0x04 pointers-equal, 0x10 buffer-end, 0x20 transfer terminal count, 0x80 DMA terminal count) is set at a clock edge where its event input is 1 and its event-enable bit (offset 5, same position) is 1. With the enable bit at 0, the event leaves the status bit unchanged.
- R3: A set status bit stays set until the host writes to offset 4 with a 1 in that bit position. Writing 0 in a position leaves that bit unchanged.
- R4: When an event sets a bit in the same cycle that a host write clears the same bit, the bit stays set.
- R5: When offset 4 is read, bit 1 (0x02) is the pending flag: 1 exactly when some status bit is 1 and its interrupt-enable bit (offset 3) is also 1. Writing a 1 to bit 1 of offset 4 has no effect.
- R6: The interrupt output is 1 exactly when, one clock earlier, the pending condition held and bit 5 (0x20) of the mode register (offset 1) was 1.
- R7: The interrupt-enable and event-enable registers store only the event positions (mask 0xB5). All other bits read 0.
- R8: The configuration (offset 0) and mode (offset 1) registers store and read back a full byte. Offsets 2, 6 and 7 read 0, and writes to them have no effect.
- R9: Event inputs at positions 1, 3 and 6 never set a status bit.
- R10: Read data is captured at the clock edge of a read-strobe cycle and is valid from then on. The status byte reads as the latched event bits OR'ed with the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | 3 | Register offset |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| evt_in | input | 8 | Event inputs, one per status bit position |
| irq_o | output | 1 | Host interrupt request |

## Verification
The hardest case to reach from the ports is an event and a host clear landing on the same bit in the same cycle. The bench creates it by raising the event input and issuing the write-1 strobe to offset 4 in a single cycle, then reading the byte back. A second difficult case is a status byte that is non-zero while the interrupt stays low. The bench produces it with events that are latched but not interrupt-enabled, and again with the mode gate bit cleared. The registered interrupt is checked both in the cycle where its gate lands and in the cycle after.

// File: rtl/evtirq_pkg.sv
package evtirq_pkg;
    localparam int DW = 8;
    localparam int AW = 3;

    localparam logic [AW-1:0] OFF_CFG  = 3'd0;
    localparam logic [AW-1:0] OFF_MODE = 3'd1;
    localparam logic [AW-1:0] OFF_IEN  = 3'd3;
    localparam logic [AW-1:0] OFF_STAT = 3'd4;
    localparam logic [AW-1:0] OFF_EEN  = 3'd5;

    // positions that carry a real event
    localparam logic [DW-1:0] EVT_MASK = 8'hB5;
    localparam int PEND_POS     = 1;
    localparam int IRQ_GATE_POS = 5;

    typedef struct packed {
        logic [DW-1:0] cfg;
        logic [DW-1:0] mode;
        logic [DW-1:0] ien;
        logic [DW-1:0] een;
        logic [DW-1:0] rdata;
    } host_regs_t;

    typedef struct packed {
        logic [DW-1:0] stat;
    } stat_regs_t;

    typedef struct packed {
        logic irq;
    } irq_regs_t;
endpackage

// File: rtl/evtirq_status.sv
module evtirq_status
    import evtirq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] evt,
    input  logic [DW-1:0] een,
    input  logic [DW-1:0] clr,
    output logic [DW-1:0] status_q
);
    stat_regs_t st_d, st_q;
    logic [DW-1:0] hit;

    always_comb begin
        st_d = st_q;
        hit  = evt & een & EVT_MASK;
        // a new event overrides a same-cycle clear
        st_d.stat = ((st_q.stat & ~clr) | hit) & EVT_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign status_q = st_q.stat;
endmodule

// File: rtl/evtirq_irq.sv
module evtirq_irq
    import evtirq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] status,
    input  logic [DW-1:0] ien,
    input  logic          gate,
    output logic          pend,
    output logic          irq_o
);
    irq_regs_t ir_d, ir_q;

    always_comb begin
        ir_d     = ir_q;
        pend     = |(status & ien);
        ir_d.irq = pend & gate;
    end

    always_ff @(posedge clk) begin
        if (rst) ir_q <= '0;
        else     ir_q <= ir_d;
    end

    assign irq_o = ir_q.irq;
endmodule

// File: rtl/evtirq_host.sv
module evtirq_host
    import evtirq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic          rd,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] status,
    input  logic          pend,
    output logic [DW-1:0] clr,
    output logic [DW-1:0] ien_q,
    output logic [DW-1:0] een_q,
    output logic          gate,
    output logic [DW-1:0] rdata
);
    host_regs_t hr_d, hr_q;
    logic [DW-1:0] rd_mux;
    logic [DW-1:0] pend_vec;

    always_comb begin
        hr_d     = hr_q;
        clr      = '0;
        pend_vec = '0;
        pend_vec[PEND_POS] = pend;

        if (wr) begin
            unique case (addr)
                OFF_CFG:  hr_d.cfg  = wdata;
                OFF_MODE: hr_d.mode = wdata;
                OFF_IEN:  hr_d.ien  = wdata & EVT_MASK;
                OFF_EEN:  hr_d.een  = wdata & EVT_MASK;
                OFF_STAT: clr       = wdata & EVT_MASK;
                default:  ;
            endcase
        end

        unique case (addr)
            OFF_CFG:  rd_mux = hr_q.cfg;
            OFF_MODE: rd_mux = hr_q.mode;
            OFF_IEN:  rd_mux = hr_q.ien;
            OFF_EEN:  rd_mux = hr_q.een;
            OFF_STAT: rd_mux = status | pend_vec;
            default:  rd_mux = '0;
        endcase

        if (rd) hr_d.rdata = rd_mux;
    end

    always_ff @(posedge clk) begin
        if (rst) hr_q <= '0;
        else     hr_q <= hr_d;
    end

    assign ien_q = hr_q.ien;
    assign een_q = hr_q.een;
    assign gate  = hr_q.mode[IRQ_GATE_POS];
    assign rdata = hr_q.rdata;
endmodule

// File: rtl/evtirq_block.sv
module evtirq_block
    import evtirq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] host_addr,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic [DW-1:0] evt_in,
    output logic          irq_o
);
    logic [DW-1:0] status_w;
    logic [DW-1:0] clr_w;
    logic [DW-1:0] ien_w;
    logic [DW-1:0] een_w;
    logic          gate_w;
    logic          pend_w;

    evtirq_host u_host (
        .clk   (clk),
        .rst   (rst),
        .addr  (host_addr),
        .wr    (host_wr),
        .rd    (host_rd),
        .wdata (host_wdata),
        .status(status_w),
        .pend  (pend_w),
        .clr   (clr_w),
        .ien_q (ien_w),
        .een_q (een_w),
        .gate  (gate_w),
        .rdata (host_rdata)
    );

    evtirq_status u_status (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt_in),
        .een     (een_w),
        .clr     (clr_w),
        .status_q(status_w)
    );

    evtirq_irq u_irq (
        .clk   (clk),
        .rst   (rst),
        .status(status_w),
        .ien   (ien_w),
        .gate  (gate_w),
        .pend  (pend_w),
        .irq_o (irq_o)
    );
endmodule

// File: rtl/evtirq_chk.sv
module evtirq_chk
    import evtirq_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] host_addr,
    input logic          host_wr,
    input logic          host_rd,
    input logic [DW-1:0] host_wdata,
    input logic [DW-1:0] host_rdata,
    input logic [DW-1:0] evt_in,
    input logic          irq_o,
    input logic [DW-1:0] status_w,
    input logic [DW-1:0] ien_w,
    input logic [DW-1:0] een_w,
    input logic          gate_w
);
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (status_w == '0 && host_rdata == '0 && irq_o == 1'b0));

    // R2 and R4: an enabled event always leaves its bit set
    p_latch_r2: assert property (@(posedge clk) disable iff (rst)
        ((evt_in & een_w & EVT_MASK) != '0) |=>
        ((status_w & $past(evt_in & een_w & EVT_MASK)) == $past(evt_in & een_w & EVT_MASK)));

    p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == OFF_STAT && ((host_wdata & evt_in & een_w & EVT_MASK) != '0)) |=>
        ((status_w & $past(host_wdata & evt_in & een_w & EVT_MASK)) != '0));

    p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        !(host_wr && host_addr == OFF_STAT) |=>
        ((status_w & $past(status_w)) == $past(status_w)));

    p_w1c_r3: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == OFF_STAT) |=>
        ((status_w & $past(host_wdata & ~(evt_in & een_w) & EVT_MASK)) == '0));

    p_pend_r5: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_addr == OFF_STAT) |=>
        (host_rdata[PEND_POS] == $past(|(status_w & ien_w))));

    p_irq_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_o == $past((|(status_w & ien_w)) && gate_w)));

    p_masks_r7: assert property (@(posedge clk) disable iff (rst)
        ((ien_w & ~EVT_MASK) == '0 && (een_w & ~EVT_MASK) == '0));

    p_dead_bits_r9: assert property (@(posedge clk) disable iff (rst)
        ((status_w & ~EVT_MASK) == '0));
endmodule

bind evtirq_block evtirq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .host_addr (host_addr),
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .evt_in    (evt_in),
    .irq_o     (irq_o),
    .status_w  (status_w),
    .ien_w     (ien_w),
    .een_w     (een_w),
    .gate_w    (gate_w)
);

// File: tb/evtirq_block_tb_top.sv
module evtirq_block_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] host_addr = '0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic [7:0] evt_in = '0;
    logic       irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_prev = 1'b0;

    // bench model, written from the requirements
    localparam logic [7:0] MASK = 8'hB5;
    logic [7:0] m_stat = '0, m_ie = '0, m_ee = '0, m_cfg = '0, m_mode = '0;

    always #5 clk = ~clk;

    evtirq_block dut_i (
        .clk       (clk),
        .rst       (rst),
        .host_addr (host_addr),
        .host_wr   (host_wr),
        .host_rd   (host_rd),
        .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .evt_in    (evt_in),
        .irq_o     (irq_o)
    );

    function automatic logic [7:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return m_cfg;
            3'd1: return m_mode;
            3'd3: return m_ie;
            3'd5: return m_ee;
            3'd4: return m_stat | (((m_stat & m_ie) != 0) ? 8'h02 : 8'h00);
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    // one bus cycle: optional write and events, model follows at the edge
    task automatic cycle(input logic [7:0] evt, input logic wr,
                         input logic [2:0] a, input logic [7:0] wd);
        logic [7:0] ns;
        @(negedge clk);
        evt_in = evt; host_wr = wr; host_addr = a; host_wdata = wd;
        @(posedge clk);
        ns = m_stat;
        if (wr && a == 3'd4) ns = ns & ~(wd & MASK);
        ns = (ns | (evt & m_ee)) & MASK;
        if (wr) begin
            case (a)
                3'd0: m_cfg  = wd;
                3'd1: m_mode = wd;
                3'd3: m_ie   = wd & MASK;
                3'd5: m_ee   = wd & MASK;
                default: ;
            endcase
        end
        m_stat = ns;
        @(negedge clk);
        evt_in = '0; host_wr = 1'b0;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] wd);
        cycle(8'h00, 1'b1, a, wd);
    endtask

    task automatic rd_reg(input logic [2:0] a, input string tag);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        exp_q.push_back(model_read(a));
        tag_q.push_back(tag);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic irq_after_edge(input logic exp, input string tag);
        @(posedge clk);
        @(negedge clk);
        check(tag, {7'd0, irq_o}, {7'd0, exp});
    endtask

    always @(posedge clk) rd_prev <= host_rd;

    // monitor: compares every read result with the scoreboard entry
    always @(negedge clk) begin
        if (rd_prev) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R10 unexpected read actual=0x%02h expected=none", host_rdata);
            end else begin
                check(tag_q.pop_front(), host_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 irq after reset", {7'd0, irq_o}, 8'h00);
        check("R1 rdata after reset", host_rdata, 8'h00);
        for (int a = 0; a < 8; a++) rd_reg(a[2:0], "R1 register reset value");

        // R8 full-byte storage, unmapped offsets
        wr_reg(3'd0, 8'hA5);
        wr_reg(3'd1, 8'h5A);
        rd_reg(3'd0, "R8 config readback");
        rd_reg(3'd1, "R8 mode readback");
        wr_reg(3'd2, 8'hFF);
        wr_reg(3'd6, 8'hFF);
        wr_reg(3'd7, 8'hFF);
        rd_reg(3'd2, "R8 offset 2 reads 0");
        rd_reg(3'd6, "R8 offset 6 reads 0");
        rd_reg(3'd7, "R8 offset 7 reads 0");
        rd_reg(3'd0, "R8 config unchanged by unmapped write");

        // R7 enable masks
        wr_reg(3'd3, 8'hFF);
        wr_reg(3'd5, 8'hFF);
        rd_reg(3'd3, "R7 interrupt enable mask");
        rd_reg(3'd5, "R7 event enable mask");

        // R2 event disabled
        wr_reg(3'd5, 8'h00);
        cycle(8'h01, 1'b0, 3'd0, 8'h00);
        rd_reg(3'd4, "R2 disabled event not latched");
        wr_reg(3'd5, 8'hB5);
        cycle(8'h01, 1'b0, 3'd0, 8'h00);
        rd_reg(3'd4, "R2 enabled event latched");

        // R9 dead positions, R10 status with pending
        cycle(8'h4A, 1'b0, 3'd0, 8'h00);
        rd_reg(3'd4, "R9 positions 1 3 6 ignored");
        cycle(8'hFF, 1'b0, 3'd0, 8'h00);
        rd_reg(3'd4, "R10 status with pending flag");

        // R3 write-one-to-clear and sticky
        wr_reg(3'd4, 8'h00);
        rd_reg(3'd4, "R3 zero write keeps bits");
        repeat (5) @(posedge clk);
        rd_reg(3'd4, "R3 bits sticky while idle");
        wr_reg(3'd4, 8'h01);
        rd_reg(3'd4, "R3 one write clears bit 0");

        // R5 pending bit is read-only
        wr_reg(3'd4, 8'h02);
        rd_reg(3'd4, "R5 write to pending ignored");

        // R4 set wins over clear
        cycle(8'h10, 1'b1, 3'd4, 8'h10);
        rd_reg(3'd4, "R4 event beats clear");

        // R6 interrupt gating
        check("R6 gate off keeps irq low", {7'd0, irq_o}, 8'h00);
        wr_reg(3'd1, 8'h20);
        check("R6 irq lags gate by one edge", {7'd0, irq_o}, 8'h00);
        irq_after_edge(1'b1, "R6 irq with gate on");
        wr_reg(3'd4, 8'hFF);
        rd_reg(3'd4, "R3 clear all");
        check("R6 irq low after clear", {7'd0, irq_o}, 8'h00);
        wr_reg(3'd3, 8'h04);
        cycle(8'h10, 1'b0, 3'd0, 8'h00);
        rd_reg(3'd4, "R5 latched but not enabled no pending");
        check("R6 irq low for masked event", {7'd0, irq_o}, 8'h00);
        cycle(8'h04, 1'b0, 3'd0, 8'h00);
        irq_after_edge(1'b1, "R6 irq for enabled event");
        rd_reg(3'd4, "R5 pending set");
        wr_reg(3'd3, 8'h00);
        irq_after_edge(1'b0, "R6 irq drops with interrupt enable");

        // R1 reset in mid-run
        wr_reg(3'd0, 8'h3C);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        m_stat = '0; m_ie = '0; m_ee = '0; m_cfg = '0; m_mode = '0;
        check("R1 irq after mid-run reset", {7'd0, irq_o}, 8'h00);
        for (int a = 0; a < 8; a++) rd_reg(a[2:0], "R1 register after mid-run reset");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL R10 reads missing actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule